// File: doc/BRIEF.md
# Serial Control Register Bank

This block lets an external host program a small set of 16-bit control words over a four-wire serial link. The link is sampled inside the system clock domain. Both the serial clock and the active-low select pass through synchronizers, and their edges are found there. Each access is one frame of exactly 24 serial clocks. The frame opens with an eight-bit header: a 6-bit register index, one reserved bit, then a direction flag. Sixteen data bits follow. All fields go most significant bit first.

On a write, the data is stored when the 24th rising edge arrives. On a read, the addressed word is sent out on the return line during the data phase. The stored values leave the block as plain configuration outputs to the acquisition logic: strobe timing, integration time, strobe enable, and baseline and saturation calibration. A fixed identification word can be read but never changed. An asynchronous active-high reset puts every writable word back to its default at once.

Top module: `spi_ctrl_regfile`

## Requirements
- R1: A frame is 24 rising serial-clock edges with select low. Bits 1-6 are the index (MSB first), bit 7 is reserved and ignored, and bit 8 is the direction flag (1 = write, 0 = read). Bits 9-24 are data, MSB first. A write takes effect on the addressed output after the 24th rising edge.
- R2: Index map (byte address = index x 4): 1 identification, 2 strobe count base, 3 strobe count, 6 integration time, 14 single-strobe low delay, 15 single-strobe high delay, 16 strobe enable, 23 offset value, 26 saturation value.
- R3: On a read, the return line carries data bit 15 after the falling edge that follows the 8th rising edge. It moves to the next lower bit on each later falling edge, so the host samples bit k on rising edge 24-k. Outside this data phase the return line is 0.
- R4: Index 1 reads as the VERSION parameter (default 0x0A51). Writes to it are ignored.
- R5: Indices outside the map read as 0x0000, and writing to them changes no output.
- R6: The strobe enable keeps only data bit 0. It reads back as 0x0000 or 0x0001.
- R7: If select goes high before the 24th rising edge, the frame is dropped and nothing is written.
- R8: Reset is asynchronous and active-high. It sets integration time to 1 and every other writable word, including the enable, to 0, without waiting for a clock edge.
- R9: Serial clocks after the 24th, with select still low, are ignored until select goes high again.
- R10: If select rises in the same synchronized cycle as the 24th rising edge, the frame is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial read data to host |
| cfg_count_base | output | 16 | Strobe count base |
| cfg_strobe_count | output | 16 | Strobe count |
| cfg_integ_time | output | 16 | Integration time |
| cfg_ss_low_dly | output | 16 | Single-strobe low delay |
| cfg_ss_high_dly | output | 16 | Single-strobe high delay |
| cfg_strobe_en | output | 1 | Strobe enable |
| cfg_offset | output | 16 | Baseline offset value |
| cfg_max_sat | output | 16 | Saturation value |

## Verification
Two things can land in the same system cycle: the synchronized select rising and the 24th rising clock edge, which would otherwise store the word. The bench provokes this by raising the serial clock and the select in the same time step on a write to the integration time. Both pass through synchronizers of equal depth, so the design sees them together. The bench then judges at the output: the integration time must keep its earlier value.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;

    localparam int FRAME_BITS = 24;
    localparam int HDR_BITS   = 8;
    localparam int IDX_W      = 6;
    localparam int DATA_W     = 16;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    typedef enum logic [IDX_W-1:0] {
        IDX_VERSION  = 6'd1,
        IDX_CNT_BASE = 6'd2,
        IDX_STRB_CNT = 6'd3,
        IDX_INTEG    = 6'd6,
        IDX_SS_LOW   = 6'd14,
        IDX_SS_HIGH  = 6'd15,
        IDX_STRB_EN  = 6'd16,
        IDX_OFFSET   = 6'd23,
        IDX_MAX_SAT  = 6'd26
    } reg_idx_e;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             rsvd;
        logic             wr;
    } hdr_t;

    typedef struct packed {
        logic [DATA_W-1:0] cnt_base;
        logic [DATA_W-1:0] strb_cnt;
        logic [DATA_W-1:0] integ;
        logic [DATA_W-1:0] ss_low;
        logic [DATA_W-1:0] ss_high;
        logic              strb_en;
        logic [DATA_W-1:0] offset;
        logic [DATA_W-1:0] max_sat;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{
        cnt_base: '0,
        strb_cnt: '0,
        integ:    DATA_W'(1),
        ss_low:   '0,
        ss_high:  '0,
        strb_en:  1'b0,
        offset:   '0,
        max_sat:  '0
    };

    function automatic hdr_t make_hdr(input logic [HDR_BITS-1:0] raw);
        return hdr_t'(raw);
    endfunction

    function automatic logic [CNT_W-1:0] cnt_of(input int n);
        return CNT_W'(n);
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import spi_regs_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_n_s,
    output logic mosi_s
);
    localparam int          NPINS   = 3;
    localparam logic [2:0]  RST_VAL = 3'b010;  // {sck, cs_n, mosi}

    logic [NPINS-1:0] pins_in;
    logic [NPINS-1:0] pins_out;
    logic             sck_prev;

    assign pins_in = {sck_in, cs_n_in, mosi_in};

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or posedge rst) begin
            if (rst) begin
                chain <= {STAGES{RST_VAL[p]}};
            end else begin
                chain <= {chain[STAGES-2:0], pins_in[p]};
            end
        end
        assign pins_out[p] = chain[STAGES-1];
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sck_prev <= 1'b0;
        end else begin
            sck_prev <= pins_out[2];
        end
    end

    assign sck_rise = pins_out[2] & ~sck_prev;
    assign sck_fall = ~pins_out[2] & sck_prev;
    assign cs_n_s   = pins_out[1];
    assign mosi_s   = pins_out[0];

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import spi_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              cs_n_s,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [DATA_W-1:0] wr_data,
    output logic              miso,
    output logic [CNT_W-1:0]  bit_cnt
);
    localparam logic [CNT_W-1:0] HDR_LAST   = cnt_of(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] HDR_DONE   = cnt_of(HDR_BITS);
    localparam logic [CNT_W-1:0] FRAME_LAST = cnt_of(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] FRAME_END  = cnt_of(FRAME_BITS);

    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] rx_sh;
    logic [DATA_W-1:0] tx_sh;
    hdr_t              hdr_q;
    hdr_t              hdr_next;
    logic              miso_q;
    logic              in_frame;
    logic              rd_phase;

    assign hdr_next = make_hdr({rx_sh[HDR_BITS-2:0], mosi_s});
    assign rd_idx   = hdr_next.idx;
    assign in_frame = (cnt_q < FRAME_END);
    assign rd_phase = (cnt_q >= HDR_DONE) && in_frame && !hdr_q.wr;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cnt_q  <= '0;
            rx_sh  <= '0;
            tx_sh  <= '0;
            hdr_q  <= '0;
            miso_q <= 1'b0;
        end else if (cs_n_s) begin
            cnt_q  <= '0;
            miso_q <= 1'b0;
        end else begin
            if (sck_rise && in_frame) begin
                rx_sh <= {rx_sh[DATA_W-2:0], mosi_s};
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == HDR_LAST) begin
                    hdr_q <= hdr_next;
                    tx_sh <= rd_data;
                end
            end
            if (sck_fall) begin
                if (rd_phase) begin
                    miso_q <= tx_sh[DATA_W-1];
                    tx_sh  <= {tx_sh[DATA_W-2:0], 1'b0};
                end else begin
                    miso_q <= 1'b0;
                end
            end
        end
    end

    assign wr_en   = !cs_n_s && sck_rise && (cnt_q == FRAME_LAST) && hdr_q.wr;
    assign wr_idx  = hdr_q.idx;
    assign wr_data = {rx_sh[DATA_W-2:0], mosi_s};
    assign miso    = miso_q;
    assign bit_cnt = cnt_q;

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
    import spi_regs_pkg::*;
#(
    parameter logic [DATA_W-1:0] VERSION = 16'h0A51
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output cfg_t              cfg
);
    cfg_t cfg_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (wr_en) begin
            case (wr_idx)
                IDX_CNT_BASE: cfg_q.cnt_base <= wr_data;
                IDX_STRB_CNT: cfg_q.strb_cnt <= wr_data;
                IDX_INTEG:    cfg_q.integ    <= wr_data;
                IDX_SS_LOW:   cfg_q.ss_low   <= wr_data;
                IDX_SS_HIGH:  cfg_q.ss_high  <= wr_data;
                IDX_STRB_EN:  cfg_q.strb_en  <= wr_data[0];
                IDX_OFFSET:   cfg_q.offset   <= wr_data;
                IDX_MAX_SAT:  cfg_q.max_sat  <= wr_data;
                default:      ;
            endcase
        end
    end

    always_comb begin
        case (rd_idx)
            IDX_VERSION:  rd_data = VERSION;
            IDX_CNT_BASE: rd_data = cfg_q.cnt_base;
            IDX_STRB_CNT: rd_data = cfg_q.strb_cnt;
            IDX_INTEG:    rd_data = cfg_q.integ;
            IDX_SS_LOW:   rd_data = cfg_q.ss_low;
            IDX_SS_HIGH:  rd_data = cfg_q.ss_high;
            IDX_STRB_EN:  rd_data = {{(DATA_W-1){1'b0}}, cfg_q.strb_en};
            IDX_OFFSET:   rd_data = cfg_q.offset;
            IDX_MAX_SAT:  rd_data = cfg_q.max_sat;
            default:      rd_data = '0;
        endcase
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/spi_ctrl_regfile.sv
module spi_ctrl_regfile
    import spi_regs_pkg::*;
#(
    parameter logic [15:0] VERSION     = 16'h0A51,
    parameter int          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        spi_sck,
    input  logic        spi_cs_n,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic [15:0] cfg_count_base,
    output logic [15:0] cfg_strobe_count,
    output logic [15:0] cfg_integ_time,
    output logic [15:0] cfg_ss_low_dly,
    output logic [15:0] cfg_ss_high_dly,
    output logic        cfg_strobe_en,
    output logic [15:0] cfg_offset,
    output logic [15:0] cfg_max_sat
);
    logic              sck_rise;
    logic              sck_fall;
    logic              cs_n_s;
    logic              mosi_s;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;
    logic [CNT_W-1:0]  bit_cnt;
    cfg_t              cfg;

    spi_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst      (rst),
        .sck_in   (spi_sck),
        .cs_n_in  (spi_cs_n),
        .mosi_in  (spi_mosi),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_n_s   (cs_n_s),
        .mosi_s   (mosi_s)
    );

    spi_frame_engine u_frame (
        .clk      (clk),
        .rst      (rst),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .cs_n_s   (cs_n_s),
        .mosi_s   (mosi_s),
        .rd_data  (rd_data),
        .rd_idx   (rd_idx),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data),
        .miso     (spi_miso),
        .bit_cnt  (bit_cnt)
    );

    spi_reg_bank #(
        .VERSION (VERSION)
    ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_data),
        .cfg     (cfg)
    );

    assign cfg_count_base   = cfg.cnt_base;
    assign cfg_strobe_count = cfg.strb_cnt;
    assign cfg_integ_time   = cfg.integ;
    assign cfg_ss_low_dly   = cfg.ss_low;
    assign cfg_ss_high_dly  = cfg.ss_high;
    assign cfg_strobe_en    = cfg.strb_en;
    assign cfg_offset       = cfg.offset;
    assign cfg_max_sat      = cfg.max_sat;

endmodule

// File: rtl/spi_ctrl_regfile_chk.sv
module spi_ctrl_regfile_chk
    import spi_regs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n_s,
    input logic              sck_fall,
    input logic              wr_en,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic              miso,
    input logic [DATA_W-1:0] count_base,
    input logic [DATA_W-1:0] integ,
    input logic              strobe_en
);
    AST_MISO_IDLE: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> (miso == 1'b0));  // R3

    AST_MISO_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (!sck_fall && !cs_n_s) |=> $stable(miso));  // R3

    AST_NO_WRITE_DESELECTED: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |-> !wr_en);  // R7

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(FRAME_BITS));  // R9

    AST_WRITE_AT_LAST: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (bit_cnt == CNT_W'(FRAME_BITS - 1)));  // R1

    AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(count_base));  // R1

    AST_INTEG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(integ));  // R1

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(strobe_en));  // R6

endmodule

bind spi_ctrl_regfile spi_ctrl_regfile_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n_s     (cs_n_s),
    .sck_fall   (sck_fall),
    .wr_en      (wr_en),
    .bit_cnt    (bit_cnt),
    .miso       (spi_miso),
    .count_base (cfg_count_base),
    .integ      (cfg_integ_time),
    .strobe_en  (cfg_strobe_en)
);

// File: tb/spi_ctrl_regfile_tb_top.sv
module spi_ctrl_regfile_tb_top;
    localparam int HALF = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sck = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic [15:0] cfg_count_base, cfg_strobe_count, cfg_integ_time;
    logic [15:0] cfg_ss_low_dly, cfg_ss_high_dly, cfg_offset, cfg_max_sat;
    logic        cfg_strobe_en;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    spi_ctrl_regfile dut_i (
        .clk              (clk),
        .rst              (rst),
        .spi_sck          (spi_sck),
        .spi_cs_n         (spi_cs_n),
        .spi_mosi         (spi_mosi),
        .spi_miso         (spi_miso),
        .cfg_count_base   (cfg_count_base),
        .cfg_strobe_count (cfg_strobe_count),
        .cfg_integ_time   (cfg_integ_time),
        .cfg_ss_low_dly   (cfg_ss_low_dly),
        .cfg_ss_high_dly  (cfg_ss_high_dly),
        .cfg_strobe_en    (cfg_strobe_en),
        .cfg_offset       (cfg_offset),
        .cfg_max_sat      (cfg_max_sat)
    );

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One frame: nclk serial clocks; bits past 24 come from tail.
    task automatic frame(input logic [5:0] idx, input logic wr, input logic [15:0] data,
                         input int nclk, input bit cs_on_last, input logic [23:0] tail);
        logic [23:0] word;
        word = {idx, 1'b0, wr, data};
        wait_clk(1);
        spi_cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = 0; i < nclk; i++) begin
            spi_sck  = 1'b0;
            spi_mosi = (i < 24) ? word[23-i] : tail[47-i];
            wait_clk(HALF);
            spi_sck = 1'b1;
            if (i == nclk - 1 && cs_on_last) spi_cs_n = 1'b1;
            wait_clk(HALF);
        end
        spi_sck = 1'b0;
        wait_clk(HALF);
        spi_cs_n = 1'b1;
        wait_clk(3 * HALF);
    endtask

    task automatic wr_reg(input logic [5:0] idx, input logic [15:0] data);
        frame(idx, 1'b1, data, 24, 1'b0, 24'h0);
    endtask

    // Driver: push the expected word, then run the read frame.
    task automatic rd_reg(input logic [5:0] idx, input logic [15:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        frame(idx, 1'b0, 16'h0000, 24, 1'b0, 24'h0);
    endtask

    // Monitor: decodes frames at the pins and scores read data.
    int          mcnt = 0;
    logic [7:0]  mhdr = '0;
    logic [15:0] mword = '0;
    bit          hdr_quiet = 1'b1;

    always @(negedge spi_cs_n) begin
        mcnt = 0;
        hdr_quiet = 1'b1;
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            if (mcnt < 8) begin
                mhdr = {mhdr[6:0], spi_mosi};
                if (spi_miso !== 1'b0) hdr_quiet = 1'b0;
            end else if (mcnt < 24) begin
                mword = {mword[14:0], spi_miso};
            end
            mcnt++;
        end
    end

    always @(posedge spi_cs_n) begin
        if (mcnt >= 24 && mhdr[0] == 1'b0) begin
            if (exp_q.size() == 0) begin
                n_cmp++;
                n_bad++;
                $display("FAIL R3: actual 0x%04h expected none queued", mword);
            end else begin
                check16(tag_q.pop_front(), mword, exp_q.pop_front());
                check16("R3 return line quiet in header", {15'b0, ~hdr_quiet}, 16'h0000);
            end
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        wait_clk(4);
        // R8 defaults while reset held
        check16("R8 integ at reset", cfg_integ_time, 16'h0001);
        check16("R8 base at reset", cfg_count_base, 16'h0000);
        check16("R8 enable at reset", {15'b0, cfg_strobe_en}, 16'h0000);
        rst = 1'b0;
        wait_clk(4);
        check16("R3 return line idle", {15'b0, spi_miso}, 16'h0000);

        rd_reg(6'd1, 16'h0A51, "R4 read identification");

        wr_reg(6'd2, 16'h1234);
        check16("R1 write strobe count base", cfg_count_base, 16'h1234);
        rd_reg(6'd2, 16'h1234, "R1 R3 read back base");

        wr_reg(6'd3, 16'hBEEF);
        wr_reg(6'd6, 16'h03E8);
        wr_reg(6'd14, 16'h0020);
        wr_reg(6'd15, 16'h0010);
        wr_reg(6'd23, 16'h07D0);
        wr_reg(6'd26, 16'hFFFF);
        check16("R2 strobe count idx 3", cfg_strobe_count, 16'hBEEF);
        check16("R2 integration idx 6", cfg_integ_time, 16'h03E8);
        check16("R2 low delay idx 14", cfg_ss_low_dly, 16'h0020);
        check16("R2 high delay idx 15", cfg_ss_high_dly, 16'h0010);
        check16("R2 offset idx 23", cfg_offset, 16'h07D0);
        check16("R2 saturation idx 26", cfg_max_sat, 16'hFFFF);
        rd_reg(6'd3, 16'hBEEF, "R2 read idx 3");
        rd_reg(6'd23, 16'h07D0, "R2 read idx 23");
        rd_reg(6'd26, 16'hFFFF, "R2 read idx 26");

        wr_reg(6'd1, 16'h0000);
        rd_reg(6'd1, 16'h0A51, "R4 identification after write");

        wr_reg(6'd5, 16'h5555);
        wr_reg(6'd63, 16'hAAAA);
        check16("R5 base after unmapped write", cfg_count_base, 16'h1234);
        check16("R5 integ after unmapped write", cfg_integ_time, 16'h03E8);
        rd_reg(6'd5, 16'h0000, "R5 read unmapped 5");
        rd_reg(6'd63, 16'h0000, "R5 read unmapped 63");

        wr_reg(6'd16, 16'hFFFF);
        check16("R6 enable set", {15'b0, cfg_strobe_en}, 16'h0001);
        rd_reg(6'd16, 16'h0001, "R6 enable reads one bit");
        wr_reg(6'd16, 16'hFFFE);
        check16("R6 enable cleared by bit 0", {15'b0, cfg_strobe_en}, 16'h0000);

        // R7: only 20 clocks
        frame(6'd2, 1'b1, 16'h9999, 20, 1'b0, 24'h0);
        check16("R7 short frame dropped", cfg_count_base, 16'h1234);
        rd_reg(6'd2, 16'h1234, "R7 read after short frame");

        // R9: 48 clocks, tail is a full write frame to idx 2
        frame(6'd2, 1'b1, 16'h4321, 48, 1'b0, {6'd2, 1'b0, 1'b1, 16'h0BAD});
        check16("R9 extra clocks ignored", cfg_count_base, 16'h4321);

        // R10: select rises with the 24th rising edge
        frame(6'd6, 1'b1, 16'h7777, 24, 1'b1, 24'h0);
        check16("R10 collision frame dropped", cfg_integ_time, 16'h03E8);

        // R8: asynchronous reset between clock edges
        @(negedge clk);
        rst = 1'b1;
        #1;
        check16("R8 async integ", cfg_integ_time, 16'h0001);
        check16("R8 async base", cfg_count_base, 16'h0000);
        check16("R8 async saturation", cfg_max_sat, 16'h0000);
        wait_clk(3);
        rst = 1'b0;
        wait_clk(3);
        rd_reg(6'd26, 16'h0000, "R8 read saturation after reset");

        wait_clk(10);
        check16("R3 scoreboard drained", 16'(exp_q.size()), 16'h0000);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule